// File: doc/BRIEF.md
# Sequential Address and IRQ Allocator

This block assigns memory-mapped address windows and interrupt line ranges to devices that register one at a time. A request carries a wanted base address, a window size, a wanted first interrupt line and a line count. A zero base or a zero first line means "assign one for me". The block then takes the value from a running free pointer and moves that pointer forward. After the free interrupt pointer advances, it steps past a small parameterised set of reserved line numbers.

Each granted device is written to the next slot of an ordered registration table, which can be read back by index. An init operation loads both free pointers and empties the table. Handing out interrupt lines past a parameterised limit sets a fatal flag. The flag is sticky and stops all further intake until reset. Address windows are not checked for overlap.

Top module: `addr_irq_alloc`

## Requirements
- R1: After reset, rsp_valid_o, fatal_o, count_o, free_base_o and free_irq_o are all zero, and req_ready_o is 1.
- R2: While init_i is high, req_ready_o is 0. At the clock edge with init_i high, free_base_o loads init_base_i, free_irq_o loads init_irq_i, and count_o becomes 0.
- R3: When req_base_i is zero, the granted base is free_base_o as it was at acceptance, and free_base_o then advances by req_size_i (modulo 2^ADDR_W).
- R4: When req_base_i is nonzero, the granted base equals req_base_i and free_base_o is unchanged.
- R5: When req_irq_i is zero and req_cnt_i is nonzero, the granted IRQ is free_irq_o as it was at acceptance, and the pointer advances by req_cnt_i.
- R6: When req_irq_i is nonzero or req_cnt_i is zero, the granted IRQ equals req_irq_i and free_irq_o is unchanged.
- R7: After an advance under R5, the pointer keeps incrementing while it equals any reserved line (defaults 5, 6, 9, 20). For example, a landing on 5 ends at 7.
- R8: If the pointer after R5/R7 is at or above MAX_IRQ (default 64), fatal_o rises at that edge. It stays high through later init operations until reset. While it is high, req_ready_o is 0.
- R9: Each granted request is stored in the next table slot in arrival order, and count_o increments. tbl_idx_i selects a slot to show its granted base, size, granted IRQ and count. An index at or above count_o shows all zeros.
- R10: A request accepted while count_o equals DEPTH (default 8) gives rsp_reject_o = 1 with zero granted values. It adds no entry, and both free pointers stay unchanged.
- R11: rsp_valid_o is high for exactly the cycle after each acceptance (req_valid_i and req_ready_o both high at an edge), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Load free pointers, empty table |
| init_base_i | input | ADDR_W | Initial free base |
| init_irq_i | input | IRQ_W | Initial free IRQ |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_base_i | input | ADDR_W | Wanted base, 0 = allocate |
| req_size_i | input | ADDR_W | Window size |
| req_irq_i | input | IRQ_W | Wanted first IRQ, 0 = allocate |
| req_cnt_i | input | CNT_W | Number of IRQ lines |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_reject_o | output | 1 | Table full, request dropped |
| rsp_base_o | output | ADDR_W | Granted base |
| rsp_irq_o | output | IRQ_W | Granted first IRQ |
| free_base_o | output | ADDR_W | Free base pointer |
| free_irq_o | output | IRQ_W | Free IRQ pointer |
| fatal_o | output | 1 | Sticky IRQ exhaustion |
| count_o | output | CW | Table entries in use |
| tbl_idx_i | input | IDX_W | Table read index |
| tbl_base_o | output | ADDR_W | Entry granted base |
| tbl_size_o | output | ADDR_W | Entry size |
| tbl_irq_o | output | IRQ_W | Entry granted IRQ |
| tbl_cnt_o | output | CNT_W | Entry IRQ count |

## Verification
The assertions assume that init_i and req_valid_i are never both high. They also assume that inputs change only away from the rising edge, and that req_cnt_i fits in IRQ_W bits. The bench drives every input on the falling edge and holds req_valid_i for one cycle per request. It raises init_i only while no request is pending. Request and init values are chosen so that the free pointers stay below the wrap of their registers, and reserved-line runs are covered only by the default reserved set.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic {
    IRQ_FIXED = 1'b0,
    IRQ_ALLOC = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/irq_skip.sv
module irq_skip #(
  parameter int IRQ_W   = 8,
  parameter int NUM_RSV = 4,
  parameter logic [NUM_RSV*IRQ_W-1:0] RSV_IRQS = '0,
  localparam int VW = IRQ_W + 2
) (
  input  logic [VW-1:0] val_i,
  output logic [VW-1:0] val_o
);
  logic [VW-1:0] stage [NUM_RSV+1];

  assign stage[0] = val_i;

  // one stage per reserved entry bounds the longest run of reserved lines
  for (genvar s = 0; s < NUM_RSV; s++) begin : g_stage
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int r = 0; r < NUM_RSV; r++) begin
        if (stage[s] == {2'b00, RSV_IRQS[r*IRQ_W +: IRQ_W]}) hit = 1'b1;
      end
    end
    assign stage[s+1] = hit ? stage[s] + VW'(1) : stage[s];
  end

  assign val_o = stage[NUM_RSV];
endmodule

// File: rtl/alloc_table.sv
module alloc_table #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int IRQ_W  = 8,
  parameter int CNT_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic [ADDR_W-1:0] wr_size_i,
  input  logic [IRQ_W-1:0]  wr_irq_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  output logic              full_o,
  output logic [CW-1:0]     count_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_base_o,
  output logic [ADDR_W-1:0] rd_size_o,
  output logic [IRQ_W-1:0]  rd_irq_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [ADDR_W-1:0] base_m [DEPTH];
  logic [ADDR_W-1:0] size_m [DEPTH];
  logic [IRQ_W-1:0]  irq_m  [DEPTH];
  logic [CNT_W-1:0]  cnt_m  [DEPTH];
  logic [CW-1:0]     count_q;
  logic              rd_ok;

  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  count_q <= '0;
    else if (clear_i)             count_q <= '0;
    else if (wr_i && !full_o)     count_q <= count_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o && !clear_i) begin
      base_m[count_q[IDX_W-1:0]] <= wr_base_i;
      size_m[count_q[IDX_W-1:0]] <= wr_size_i;
      irq_m[count_q[IDX_W-1:0]]  <= wr_irq_i;
      cnt_m[count_q[IDX_W-1:0]]  <= wr_cnt_i;
    end
  end

  assign rd_ok     = (CW'(rd_idx_i) < count_q);
  assign rd_base_o = rd_ok ? base_m[rd_idx_i] : '0;
  assign rd_size_o = rd_ok ? size_m[rd_idx_i] : '0;
  assign rd_irq_o  = rd_ok ? irq_m[rd_idx_i]  : '0;
  assign rd_cnt_o  = rd_ok ? cnt_m[rd_idx_i]  : '0;

  // R9
  append_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_o && !clear_i) |=> (count_o == $past(count_o) + CW'(1)));
  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clear_i) |=> full_o);
endmodule

// File: rtl/addr_irq_alloc.sv
module addr_irq_alloc
  import alloc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IRQ_W   = 8,
  parameter int CNT_W   = 8,
  parameter int DEPTH   = 8,
  parameter int MAX_IRQ = 64,
  parameter int NUM_RSV = 4,
  parameter logic [NUM_RSV*IRQ_W-1:0] RSV_IRQS = {8'd20, 8'd9, 8'd6, 8'd5},
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] init_base_i,
  input  logic [IRQ_W-1:0]  init_irq_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [ADDR_W-1:0] req_size_i,
  input  logic [IRQ_W-1:0]  req_irq_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  output logic              rsp_valid_o,
  output logic              rsp_reject_o,
  output logic [ADDR_W-1:0] rsp_base_o,
  output logic [IRQ_W-1:0]  rsp_irq_o,
  output logic [ADDR_W-1:0] free_base_o,
  output logic [IRQ_W-1:0]  free_irq_o,
  output logic              fatal_o,
  output logic [CW-1:0]     count_o,
  input  logic [IDX_W-1:0]  tbl_idx_i,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [ADDR_W-1:0] tbl_size_o,
  output logic [IRQ_W-1:0]  tbl_irq_o,
  output logic [CNT_W-1:0]  tbl_cnt_o
);
  localparam int VW = IRQ_W + 2;
  localparam logic [VW-1:0] MAX_V = VW'(MAX_IRQ);

  logic [ADDR_W-1:0] free_base_q;
  logic [IRQ_W-1:0]  free_irq_q;
  logic              fatal_q;
  logic              rsp_valid_q, rsp_reject_q;
  logic [ADDR_W-1:0] rsp_base_q;
  logic [IRQ_W-1:0]  rsp_irq_q;

  logic              accept, full, grant;
  irq_mode_e         irq_mode;
  logic [ADDR_W-1:0] g_base;
  logic [IRQ_W-1:0]  g_irq;
  logic [VW-1:0]     irq_sum, irq_next;
  logic              irq_over;

  assign req_ready_o = !init_i && !fatal_q;
  assign accept      = req_valid_i && req_ready_o;
  assign grant       = accept && !full;

  assign irq_mode = ((req_irq_i == '0) && (req_cnt_i != '0)) ? IRQ_ALLOC : IRQ_FIXED;
  assign g_base   = (req_base_i == '0) ? free_base_q : req_base_i;
  assign g_irq    = (irq_mode == IRQ_ALLOC) ? free_irq_q : req_irq_i;
  assign irq_sum  = VW'(free_irq_q) + VW'(req_cnt_i);

  irq_skip #(
    .IRQ_W   (IRQ_W),
    .NUM_RSV (NUM_RSV),
    .RSV_IRQS(RSV_IRQS)
  ) u_skip (
    .val_i(irq_sum),
    .val_o(irq_next)
  );

  assign irq_over = (irq_next >= MAX_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_base_q <= '0;
      free_irq_q  <= '0;
    end else if (init_i) begin
      free_base_q <= init_base_i;
      free_irq_q  <= init_irq_i;
    end else if (grant) begin
      if (req_base_i == '0)     free_base_q <= free_base_q + req_size_i;
      if (irq_mode == IRQ_ALLOC) free_irq_q  <= irq_next[IRQ_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        fatal_q <= 1'b0;
    else if (grant && irq_mode == IRQ_ALLOC && irq_over) fatal_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_reject_q <= 1'b0;
      rsp_base_q   <= '0;
      rsp_irq_q    <= '0;
    end else begin
      rsp_valid_q  <= accept;
      rsp_reject_q <= accept && full;
      rsp_base_q   <= grant ? g_base : '0;
      rsp_irq_q    <= grant ? g_irq  : '0;
    end
  end

  alloc_table #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .IRQ_W (IRQ_W),
    .CNT_W (CNT_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (init_i),
    .wr_i     (accept),
    .wr_base_i(g_base),
    .wr_size_i(req_size_i),
    .wr_irq_i (g_irq),
    .wr_cnt_i (req_cnt_i),
    .full_o   (full),
    .count_o  (count_o),
    .rd_idx_i (tbl_idx_i),
    .rd_base_o(tbl_base_o),
    .rd_size_o(tbl_size_o),
    .rd_irq_o (tbl_irq_o),
    .rd_cnt_o (tbl_cnt_o)
  );

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_reject_o = rsp_reject_q;
  assign rsp_base_o   = rsp_base_q;
  assign rsp_irq_o    = rsp_irq_q;
  assign free_base_o  = free_base_q;
  assign free_irq_o   = free_irq_q;
  assign fatal_o      = fatal_q;

  // R11
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
  // R8
  fatal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  // R8
  fatal_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !req_ready_o);
  // R8
  fatal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_o) |-> $past(req_valid_i && req_ready_o));
  // R10
  reject_keeps_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_reject_o && !$past(init_i)) |-> ($stable(free_base_o) && $stable(free_irq_o)));
  // R4
  fixed_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_base_i != '0) |=> $stable(free_base_o));
endmodule

// File: tb/addr_irq_alloc_test.sv
module addr_irq_alloc_test;
  localparam int NV = 6;
  localparam logic [31:0] V_BASE [NV] = '{32'h0, 32'h0, 32'h2000_0000, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_SIZE [NV] = '{32'h1000, 32'h2000, 32'h100, 32'h800, 32'h400, 32'h400};
  localparam logic [7:0]  V_IRQ  [NV] = '{8'd0, 8'd0, 8'd0, 8'd11, 8'd0, 8'd0};
  localparam logic [7:0]  V_CNT  [NV] = '{8'd1, 8'd1, 8'd2, 8'd3, 8'd0, 8'd1};
  localparam logic [31:0] E_GB   [NV] = '{32'h1000_0000, 32'h1000_1000, 32'h2000_0000,
                                          32'h1000_3000, 32'h1000_3800, 32'h1000_3C00};
  localparam logic [7:0]  E_GI   [NV] = '{8'd3, 8'd4, 8'd7, 8'd11, 8'd0, 8'd10};
  localparam logic [31:0] E_FB   [NV] = '{32'h1000_1000, 32'h1000_3000, 32'h1000_3000,
                                          32'h1000_3800, 32'h1000_3C00, 32'h1000_4000};
  localparam logic [7:0]  E_FI   [NV] = '{8'd4, 8'd7, 8'd10, 8'd10, 8'd10, 8'd11};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic [31:0] init_base_i = '0;
  logic [7:0]  init_irq_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_base_i = '0, req_size_i = '0;
  logic [7:0]  req_irq_i = '0, req_cnt_i = '0;
  logic        rsp_valid_o, rsp_reject_o, fatal_o;
  logic [31:0] rsp_base_o, free_base_o, tbl_base_o, tbl_size_o;
  logic [7:0]  rsp_irq_o, free_irq_o, tbl_irq_o, tbl_cnt_o;
  logic [3:0]  count_o;
  logic [2:0]  tbl_idx_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  addr_irq_alloc uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] b, input logic [31:0] s,
                      input logic [7:0] i, input logic [7:0] c);
    @(negedge clk_i);
    req_base_i = b; req_size_i = s; req_irq_i = i; req_cnt_i = c;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic do_init(input logic [31:0] b, input logic [7:0] i);
    @(negedge clk_i);
    init_i = 1'b1; init_base_i = b; init_irq_i = i;
    #1 chk("R2 ready low in init", 32'(req_ready_o), 32'd0);
    @(negedge clk_i);
    init_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1 fatal", 32'(fatal_o), 0);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 free_base", free_base_o, 0);
    chk("R1 free_irq", 32'(free_irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", 32'(req_ready_o), 1);

    do_init(32'h1000_0000, 8'd3);
    chk("R2 free_base", free_base_o, 32'h1000_0000);
    chk("R2 free_irq", 32'(free_irq_o), 3);

    // R3 R4 R5 R6 R7 R11 vector walk
    for (int k = 0; k < NV; k++) begin
      send(V_BASE[k], V_SIZE[k], V_IRQ[k], V_CNT[k]);
      chk($sformatf("R11 rsp_valid v%0d", k), 32'(rsp_valid_o), 1);
      chk($sformatf("R3/R4 granted base v%0d", k), rsp_base_o, E_GB[k]);
      chk($sformatf("R5/R6 granted irq v%0d", k), 32'(rsp_irq_o), 32'(E_GI[k]));
      chk($sformatf("R3/R4 free_base v%0d", k), free_base_o, E_FB[k]);
      chk($sformatf("R5/R6/R7 free_irq v%0d", k), 32'(free_irq_o), 32'(E_FI[k]));
      chk($sformatf("R10 no reject v%0d", k), 32'(rsp_reject_o), 0);
    end
    @(negedge clk_i);
    chk("R11 strobe single cycle", 32'(rsp_valid_o), 0);

    // R9 table contents
    chk("R9 count", 32'(count_o), 6);
    tbl_idx_i = 3'd0; #1;
    chk("R9 e0 base", tbl_base_o, 32'h1000_0000);
    chk("R9 e0 size", tbl_size_o, 32'h1000);
    chk("R9 e0 irq", 32'(tbl_irq_o), 3);
    chk("R9 e0 cnt", 32'(tbl_cnt_o), 1);
    tbl_idx_i = 3'd5; #1;
    chk("R9 tail base", tbl_base_o, 32'h1000_3C00);
    chk("R9 tail irq", 32'(tbl_irq_o), 10);
    tbl_idx_i = 3'd6; #1;
    chk("R9 unused slot", tbl_base_o, 0);

    // R10 fill and overflow the table
    send(32'h0, 32'h100, 8'd0, 8'd1);
    chk("R5 irq 11", 32'(rsp_irq_o), 11);
    send(32'h0, 32'h100, 8'd0, 8'd1);
    chk("R5 irq 12", 32'(rsp_irq_o), 12);
    chk("R10 full count", 32'(count_o), 8);
    send(32'h0, 32'h100, 8'd0, 8'd1);
    chk("R10 rsp_valid", 32'(rsp_valid_o), 1);
    chk("R10 reject", 32'(rsp_reject_o), 1);
    chk("R10 zero base", rsp_base_o, 0);
    chk("R10 count held", 32'(count_o), 8);
    chk("R10 free_base held", free_base_o, 32'h1000_4200);
    chk("R10 free_irq held", 32'(free_irq_o), 13);
    tbl_idx_i = 3'd7; #1;
    chk("R10 last slot intact", 32'(tbl_irq_o), 12);

    // R8 exhaustion
    do_init(32'h4000_0000, 8'd60);
    chk("R2 table emptied", 32'(count_o), 0);
    send(32'h0, 32'h10, 8'd0, 8'd3);
    chk("R8 irq 60", 32'(rsp_irq_o), 60);
    chk("R8 no fatal at 63", 32'(fatal_o), 0);
    send(32'h0, 32'h10, 8'd0, 8'd1);
    chk("R8 irq 63", 32'(rsp_irq_o), 63);
    chk("R8 fatal", 32'(fatal_o), 1);
    chk("R8 ready low", 32'(req_ready_o), 0);
    do_init(32'h0, 8'd1);
    chk("R8 fatal after init", 32'(fatal_o), 1);

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 fatal cleared", 32'(fatal_o), 0);
    chk("R1 count cleared", 32'(count_o), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule